// File: doc/BRIEF.md
# Two-Wire Slave Register Read Engine

This block is the serial front end of a small register file that is read over a two-wire bus. SCL and SDA are oversampled in the system clock domain, and START and STOP conditions are recognised in every state. The block compares the incoming device address with a fixed 7-bit identity. A write-direction transfer carries a two-byte register address into an internal pointer. Data is returned from a parallel, combinational read port into the register array.

Three kinds of read are supported:
- A current-address read starts at the pointer.
- A random read sets the pointer first and then sends a repeated START in the read direction.
- A sequential read extends either of the above: the master keeps acknowledging, and the pointer steps through the register space, wrapping around at the end.

A STOP in place of the repeated START still keeps the new pointer value, so a later current-address read begins there. SDA is open-drain. The block only ever pulls it low through `sda_oe`, and `sda_o` is held at zero.

Top module: `twi_reg_reader`

## Requirements
- R1: After reset the block does not drive SDA (`sda_oe` = 0), and the pointer selects register 0, so a first current-address read returns register 0.
- R2: A device address byte whose upper seven bits equal `SLV_ADDR` is acknowledged (SDA low in the ninth bit). A byte with any other value is not acknowledged, and the block stays off the bus (the master reads 0xFF) until the next START.
- R3: In a write-direction transfer the high register-address byte comes first and the low byte second. Each byte is acknowledged. The 16-bit value is reduced modulo `REG_BYTES`. A repeated START with R/W=1 then returns the data at that address.
- R4: When a STOP follows the low address byte, the pointer keeps the loaded value, and the next current-address read returns that register.
- R5: Each data byte is sent MSB first. After a master ACK (SDA low in the ninth bit) the block sends the byte at the next address.
- R6: After the last register (`REG_BYTES`-1), the pointer rolls over to register 0 and a sequential read continues.
- R7: After a master NACK (SDA high in the ninth bit) the block releases SDA and drives nothing until a new START.
- R8: The block changes `sda_oe` only while SCL is low.
- R9: A START is honoured in any state. It discards a partial transfer and leaves the pointer unchanged. After a STOP, bytes clocked without a START are not acknowledged.
- R10: The pointer advances after every data byte sent, including the final NACKed one, so a later current-address read continues from the next register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_o | output | 1 | Data driven when enabled (always 0) |
| sda_oe | output | 1 | Pull SDA low when 1 |
| rd_addr | output | $clog2(REG_BYTES) | Register array read address |
| rd_data | input | 8 | Register array read data, combinational from `rd_addr` |

## Verification
Two events can fall in the same cycle at the end of a sent byte: the pointer advances, and that same new value then feeds the fetch of the byte the master will get after its ACK. This is sharpest at the top of the register space, where the advance is also a rollover. The bench provokes it with a random read at address 0xFE that acknowledges three bytes in a row and expects the values of registers 0xFE, 0xFF, 0x00 and 0x01. A following current-address read must return register 0x02, which shows that the increment on the NACKed byte was not lost.

// File: rtl/twi_pkg.sv
// Package: shared constants and the protocol state type for the two-wire
// register read engine. Assumes byte-wide data on the bus.
package twi_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,     // waiting for START
        ST_DEV,      // shifting in device address byte
        ST_DEV_ACK,  // acknowledge slot after device address
        ST_AHI,      // shifting in high register address byte
        ST_AHI_ACK,  // acknowledge slot after high byte
        ST_ALO,      // shifting in low register address byte
        ST_ALO_ACK,  // acknowledge slot after low byte
        ST_SKIP,     // further write bytes ignored
        ST_TX,       // shifting out a data byte
        ST_TX_ACK    // master acknowledge slot after data byte
    } twi_state_e;

endpackage

// File: rtl/twi_line_sync.sv
// Module: synchronises SCL and SDA into the system clock domain and derives
// clock edges plus START / STOP conditions. Assumes the system clock runs
// several times faster than SCL, so each bus level lasts many cycles.
module twi_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_chain;
    logic [SYNC_STAGES-1:0] sda_chain;
    logic                   scl_prev;
    logic                   sda_prev;

    // Shift raw bus lines through the synchroniser chain (idle bus is high).
    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= scl_i;
                    sda_chain <= sda_i;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
                    sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    // Remember previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_chain[LAST];
            sda_prev <= sda_chain[LAST];
        end
    end

    // Decode edges and bus conditions from current and previous levels.
    always_comb begin
        scl_lvl   = scl_chain[LAST];
        sda_lvl   = sda_chain[LAST];
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end

    // R9
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_evt && stop_evt));

    // R9
    cond_needs_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt || stop_evt) |-> (!scl_rise && !scl_fall));

endmodule

// File: rtl/twi_addr_ptr.sv
// Module: register address pointer. Loads a 16-bit received address reduced
// modulo the register space size and advances with rollover after each byte
// sent. Assumes load and inc are never requested in the same cycle.
module twi_addr_ptr #(
    parameter int REG_BYTES = 256
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [15:0]                  load_val,
    input  logic                         inc,
    output logic [$clog2(REG_BYTES)-1:0] ptr
);

    localparam int AW = $clog2(REG_BYTES);
    localparam logic [AW-1:0] TOP = AW'(REG_BYTES - 1);

    logic [AW-1:0] load_mod;
    logic [AW-1:0] ptr_next;

    // Reduce the incoming address into the register space and form successor.
    always_comb begin
        load_mod = AW'(32'(load_val) % REG_BYTES);
        ptr_next = (ptr == TOP) ? '0 : ptr + 1'b1;
    end

    // Hold, load or advance the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_mod;
        end else if (inc) begin
            ptr <= ptr_next;
        end
    end

    // R6
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && ptr == TOP) |=> (ptr == '0));

    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable(ptr));

    // R10
    ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= TOP);

endmodule

// File: rtl/twi_reg_reader.sv
// Module: two-wire slave that serves reads from a register array. Receives
// device address and a two-byte register address, then sends bytes from the
// pointer with auto-increment. Assumes rd_data is combinational from rd_addr
// and that the system clock oversamples SCL by a wide margin.
module twi_reg_reader #(
    parameter logic [6:0] SLV_ADDR    = 7'h6F,
    parameter int         REG_BYTES   = 256,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scl_i,
    input  logic                         sda_i,
    output logic                         sda_o,
    output logic                         sda_oe,
    output logic [$clog2(REG_BYTES)-1:0] rd_addr,
    input  logic [twi_pkg::BYTE_W-1:0]   rd_data
);
    import twi_pkg::*;

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    twi_state_e          st;
    logic [CNT_W-1:0]    bit_cnt;
    logic [BYTE_W-1:0]   shreg;
    logic [BYTE_W-1:0]   hi_byte;
    logic                rw_bit;
    logic                mst_ack;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic ptr_load, ptr_inc;
    logic byte_done;

    twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    // Strobes for pointer load (end of low byte) and advance (end of sent byte).
    always_comb begin
        byte_done = scl_fall && (bit_cnt == FULL) && !start_evt && !stop_evt;
        ptr_load  = byte_done && (st == ST_ALO);
        ptr_inc   = byte_done && (st == ST_TX);
        sda_o     = 1'b0;
    end

    twi_addr_ptr #(.REG_BYTES(REG_BYTES)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val ({hi_byte, shreg}),
        .inc      (ptr_inc),
        .ptr      (rd_addr)
    );

    // Protocol sequencer: bit shifting, acknowledge control and state moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            hi_byte <= '0;
            rw_bit  <= 1'b0;
            mst_ack <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (start_evt) begin
            st      <= ST_DEV;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (stop_evt) begin
            st      <= ST_IDLE;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else begin
            unique case (st)
                ST_DEV, ST_AHI, ST_ALO: begin
                    if (scl_rise && bit_cnt != FULL) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_done) begin
                        bit_cnt <= '0;
                        if (st == ST_DEV) begin
                            if (shreg[BYTE_W-1:1] == SLV_ADDR) begin
                                rw_bit <= shreg[0];
                                sda_oe <= 1'b1;
                                st     <= ST_DEV_ACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else if (st == ST_AHI) begin
                            hi_byte <= shreg;
                            sda_oe  <= 1'b1;
                            st      <= ST_AHI_ACK;
                        end else begin
                            sda_oe <= 1'b1;
                            st     <= ST_ALO_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        if (rw_bit) begin
                            shreg   <= rd_data;
                            sda_oe  <= ~rd_data[BYTE_W-1];
                            bit_cnt <= '0;
                            st      <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= ST_AHI;
                        end
                    end
                end
                ST_AHI_ACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        st     <= ST_ALO;
                    end
                end
                ST_ALO_ACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        st     <= ST_SKIP;
                    end
                end
                ST_TX: begin
                    if (scl_rise && bit_cnt != FULL) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_done) begin
                        bit_cnt <= '0;
                        sda_oe  <= 1'b0;
                        st      <= ST_TX_ACK;
                    end else if (scl_fall) begin
                        shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~shreg[BYTE_W-2];
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        mst_ack <= ~sda_lvl;
                    end else if (scl_fall) begin
                        if (mst_ack) begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                            st     <= ST_TX;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

    // R8
    sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));

    // R7
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

    // R2
    ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DEV_ACK && sda_oe) |-> (shreg[BYTE_W-1:1] == SLV_ADDR));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !start_evt) |=> !sda_oe);

endmodule

// File: tb/twi_reg_reader_tb.sv
module twi_reg_reader_tb;

    localparam logic [6:0] DEV = 7'h6F;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_o, sda_oe;
    logic [7:0] rd_addr;
    logic [7:0] rd_data;
    logic sda_bus;

    int checks = 0;
    int errors = 0;
    int r8_viol = 0;
    logic prev_oe = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] reg_val(input logic [7:0] a);
        return {a[3:0], a[7:4]} ^ 8'h5A;
    endfunction

    assign rd_data = reg_val(rd_addr);
    assign sda_bus = m_sda & ~(sda_oe & ~sda_o);

    twi_reg_reader #(.SLV_ADDR(DEV), .REG_BYTES(256), .SYNC_STAGES(2)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (m_scl),
        .sda_i   (sda_bus),
        .sda_o   (sda_o),
        .sda_oe  (sda_oe),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // R8 monitor: output enable must not change while SCL is high.
    always @(negedge clk) begin
        if (rst_n && m_scl && sda_oe !== prev_oe) r8_viol++;
        prev_oe <= sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_scl = 1'b0; wq(); m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        m_scl = 1'b0; wq();
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq();
        end
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); acked = !sda_bus; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); m_scl = 1'b1; wq(); d[i] = sda_bus; wq(); m_scl = 1'b0;
        end
        wq(); m_sda = !mack; wq(); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq(); m_sda = 1'b1;
    endtask

    // Write-direction header with a two-byte register address.
    task automatic set_addr(input logic [15:0] a, input string req);
        logic ak;
        bus_start();
        send_byte({DEV, 1'b0}, ak); chk({req, " dev ack"}, ak, 1);
        send_byte(a[15:8], ak);     chk({req, " hi ack"}, ak, 1);
        send_byte(a[7:0], ak);      chk({req, " lo ack"}, ak, 1);
    endtask

    task automatic t_reset();
        chk("R1 oe after reset", sda_oe, 0);
        t_current(8'h00, "R1 first read");
    endtask

    task automatic t_current(input logic [7:0] exp_addr, input string req);
        logic ak; logic [7:0] d;
        bus_start();
        send_byte({DEV, 1'b1}, ak); chk({req, " ack"}, ak, 1);
        recv_byte(1'b0, d);         chk(req, d, reg_val(exp_addr));
        bus_stop();
    endtask

    task automatic t_random(input logic [15:0] a, input logic [7:0] exp_addr);
        logic ak; logic [7:0] d;
        set_addr(a, "R3");
        bus_start();
        send_byte({DEV, 1'b1}, ak); chk("R3 read ack", ak, 1);
        recv_byte(1'b0, d);         chk("R3 random data", d, reg_val(exp_addr));
        bus_stop();
    endtask

    task automatic t_set_only();
        set_addr(16'h0040, "R4");
        bus_stop();
        t_current(8'h40, "R4 current after set");
    endtask

    task automatic t_seq(input logic [7:0] a, input int n, input string req);
        logic ak; logic [7:0] d;
        set_addr({8'h00, a}, req);
        bus_start();
        send_byte({DEV, 1'b1}, ak); chk({req, " read ack"}, ak, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, d);
            chk(req, d, reg_val(a + 8'(k)));
        end
        bus_stop();
    endtask

    task automatic t_nack(input logic [7:0] exp_addr);
        logic ak; logic [7:0] d;
        bus_start();
        send_byte({DEV, 1'b1}, ak);
        recv_byte(1'b0, d); chk("R7 data before nack", d, reg_val(exp_addr));
        chk("R7 oe after nack", sda_oe, 0);
        recv_byte(1'b0, d); chk("R7 silent after nack", d, 8'hFF);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic ak; logic [7:0] d;
        bus_start();
        send_byte({7'h12, 1'b1}, ak); chk("R2 mismatch nack", ak, 0);
        recv_byte(1'b0, d);           chk("R2 silent after mismatch", d, 8'hFF);
        bus_stop();
    endtask

    task automatic t_no_start();
        logic ak;
        send_byte({DEV, 1'b1}, ak); chk("R9 no ack without start", ak, 0);
        bus_stop();
    endtask

    task automatic t_abort(input logic [7:0] exp_addr);
        logic ak;
        bus_start();
        send_byte({DEV, 1'b0}, ak); chk("R9 abort dev ack", ak, 1);
        send_byte(8'h77, ak);       chk("R9 abort hi ack", ak, 1);
        t_current(exp_addr, "R9 pointer kept after restart");
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();                          // pointer now 0x01
        t_random(16'h0010, 8'h10);          // R3
        t_random(16'h0312, 8'h12);          // R3 modulo
        t_set_only();                       // R4, pointer 0x41
        t_seq(8'h20, 4, "R5 sequential");   // pointer 0x24
        t_current(8'h24, "R10 continue");   // pointer 0x25
        t_seq(8'hFE, 4, "R6 wrap");         // pointer 0x02
        t_nack(8'h02);                      // R7, pointer 0x03
        t_mismatch();                       // R2
        t_no_start();                       // R9
        t_abort(8'h03);                     // R9
        chk("R8 oe changes with SCL high", r8_viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule